// File: doc/BRIEF.md
# Auxiliary Control Register with Timer Toggle Outputs and Reset Requests

This block holds one 8-bit control register on a small special-function bus. The bus has an address, a write strobe, write data and a combinational read-data return. The register gathers several unrelated control bits:

- a select between two data pointers;
- a low-power choice for the clock circuits;
- two enables that turn timer overflow pulses into square waves at half the overflow rate;
- an enable that lets a detected serial-line break reset the chip;
- a software reset request.

The timers, the break detector and the reset sequencer are not part of this block. Overflows and breaks arrive as one-cycle input pulses. Reset requests leave as one-cycle output pulses.

Bit 2 of the register is tied to zero and bit 1 is never stored. Reading the register, adding one and writing the sum back therefore flips only the pointer-select bit. A reset request comes from one of two places: a software write with the reset bit set, or a break that arrives while the break enable is set. Either request clears the register and both toggle outputs in the cycle after the pulse, the same as a hardware reset would. A break-caused request also carries a flag that tells the sequencer to enter the programming mode.

Top module: `aux_ctrl_reg`

## Requirements
- R1: After rst_n is released, the register reads 0 at address A2h and every output is 0.
- R2: A write takes effect on the rising edge where sfr_we is 1 and sfr_addr is A2h. The field positions are:
  - bit 7: clock low-power, driven on clk_lowpwr;
  - bit 6: break reset enable;
  - bit 5: toggle-1 enable;
  - bit 4: toggle-0 enable;
  - bit 3: software reset;
  - bit 0: pointer select, driven on dptr_sel.
  
  The stored value reads back on sfr_rdata while sfr_addr is A2h.
- R3: Bits 2 and 1 always read 0, whatever was written to them. Reading the register, adding 1 and writing the sum back inverts bit 0 and leaves bits 7..3 unchanged.
- R4: While sfr_addr is not A2h, sfr_rdata is 0. A write to any other address leaves the register unchanged.
- R5: A write to A2h with bit 3 set makes chip_rst_req 1 for exactly the one cycle after the write edge, with force_prog staying 0. In that cycle the register still reads the written value, and a write made in that cycle is ignored. At the next edge the register and both toggle outputs return to 0.
- R6: While bit 4 is 1, tog0_out inverts at every rising edge where t0_ovf is 1. While bit 4 is 0, tog0_out holds its level.
- R7: While bit 5 is 1, tog1_out inverts at every rising edge where t1_ovf is 1. While bit 5 is 0, tog1_out holds its level. The two toggles are independent.
- R8: A brk_det pulse while bit 6 is 1 makes both chip_rst_req and force_prog 1 for exactly the next cycle. At the following edge the register and toggles clear.
- R9: A brk_det pulse while bit 6 is 0 has no effect: chip_rst_req and force_prog stay 0, and the register reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Bus address |
| sfr_we | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, register value at A2h, else 0 |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| brk_det | input | 1 | Serial break detected pulse |
| tog0_out | output | 1 | Square wave from timer 0 overflows |
| tog1_out | output | 1 | Square wave from timer 1 overflows |
| dptr_sel | output | 1 | Data pointer select |
| clk_lowpwr | output | 1 | Clock low-power select |
| chip_rst_req | output | 1 | One-cycle chip reset request |
| force_prog | output | 1 | One-cycle flag: enter programming mode with the reset |

## Verification
Read data is combinational, so it is due in the same cycle the address is applied. A written field, a toggle inversion or a reset-request pulse shows up in the cycle right after the edge that captured the stimulus. The register clearing caused by a request shows up one cycle later again. The bench drives inputs on the falling edge and advances its reference model on the rising edge, the same edge the design uses. It compares every output on the next falling edge, so each result is checked exactly in the cycle its latency puts it in.

// File: rtl/aux_ctrl_pkg.sv
package aux_ctrl_pkg;

  localparam int REG_W   = 8;
  localparam int NUM_TOG = 2;

  typedef struct packed {
    logic clk_lp;
    logic brk_en;
    logic tog1_en;
    logic tog0_en;
    logic srst;
    logic zero_b;
    logic spare_b;
    logic dptr;
  } aux_fields_t;

  // Force the constant bits: bit 2 is tied low, bit 1 is not kept.
  function automatic aux_fields_t sanitize(input logic [REG_W-1:0] raw);
    aux_fields_t f;
    f = aux_fields_t'(raw);
    f.zero_b  = 1'b0;
    f.spare_b = 1'b0;
    return f;
  endfunction

  // Next level of a toggle stage.
  function automatic logic toggle_next(input logic q, input logic en,
                                       input logic ovf, input logic clr);
    logic n;
    if (clr)            n = 1'b0;
    else if (en && ovf) n = ~q;
    else                n = q;
    return n;
  endfunction

endpackage

// File: rtl/aux_ctrl_fields.sv
module aux_ctrl_fields
  import aux_ctrl_pkg::*;
#(
  parameter int                 ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]  REG_ADDR = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  input  logic              clear,
  output logic              wr_hit,
  output aux_fields_t       fields
);

  logic addr_hit;
  assign addr_hit = (addr == REG_ADDR);
  assign wr_hit   = we && addr_hit && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fields <= '0;
    else if (clear)  fields <= '0;
    else if (wr_hit) fields <= sanitize(wdata);
  end

endmodule

// File: rtl/aux_toggle_out.sv
module aux_toggle_out
  import aux_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ovf,
  input  logic clear,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= toggle_next(q, en, ovf, clear);
  end

endmodule

// File: rtl/aux_reset_ctl.sv
module aux_reset_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_evt,
  input  logic brk_evt,
  output logic rst_req,
  output logic prog_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      prog_req <= 1'b0;
    end else begin
      rst_req  <= sw_evt || brk_evt;
      prog_req <= brk_evt;
    end
  end

endmodule

// File: rtl/aux_ctrl_reg.sv
module aux_ctrl_reg
  import aux_ctrl_pkg::*;
#(
  parameter int                 ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]  REG_ADDR = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_we,
  input  logic [REG_W-1:0]  sfr_wdata,
  output logic [REG_W-1:0]  sfr_rdata,
  input  logic              t0_ovf,
  input  logic              t1_ovf,
  input  logic              brk_det,
  output logic              tog0_out,
  output logic              tog1_out,
  output logic              dptr_sel,
  output logic              clk_lowpwr,
  output logic              chip_rst_req,
  output logic              force_prog
);

  aux_fields_t        cur;
  logic               wr_hit;
  logic               soft_clear;
  logic               sw_rst_evt;
  logic               brk_rst_evt;
  logic               brk_en_w;
  logic [NUM_TOG-1:0] tog_en_w;
  logic [NUM_TOG-1:0] ovf_w;
  logic [NUM_TOG-1:0] tog_q;

  // A pending request clears the block at the next edge.
  assign soft_clear = chip_rst_req;

  aux_ctrl_fields #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_fields (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (sfr_addr),
    .we     (sfr_we),
    .wdata  (sfr_wdata),
    .clear  (soft_clear),
    .wr_hit (wr_hit),
    .fields (cur)
  );

  assign brk_en_w    = cur.brk_en;
  assign sw_rst_evt  = wr_hit && sfr_wdata[3];
  assign brk_rst_evt = brk_det && brk_en_w && !soft_clear;

  aux_reset_ctl u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_evt   (sw_rst_evt),
    .brk_evt  (brk_rst_evt),
    .rst_req  (chip_rst_req),
    .prog_req (force_prog)
  );

  assign tog_en_w = {cur.tog1_en, cur.tog0_en};
  assign ovf_w    = {t1_ovf, t0_ovf};

  for (genvar i = 0; i < NUM_TOG; i++) begin : g_tog
    aux_toggle_out u_tog (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tog_en_w[i]),
      .ovf   (ovf_w[i]),
      .clear (soft_clear),
      .q     (tog_q[i])
    );
  end

  assign tog0_out   = tog_q[0];
  assign tog1_out   = tog_q[1];
  assign dptr_sel   = cur.dptr;
  assign clk_lowpwr = cur.clk_lp;
  assign sfr_rdata  = (sfr_addr == REG_ADDR) ? REG_W'(cur) : '0;

endmodule

// File: rtl/aux_ctrl_chk.sv
module aux_ctrl_chk #(
  parameter int                 ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]  REG_ADDR = 8'hA2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_we,
  input logic [7:0]        sfr_wdata,
  input logic [7:0]        sfr_rdata,
  input logic              t0_ovf,
  input logic              t1_ovf,
  input logic              brk_det,
  input logic              tog0_out,
  input logic              tog1_out,
  input logic              dptr_sel,
  input logic              clk_lowpwr,
  input logic              chip_rst_req,
  input logic              force_prog,
  input logic              brk_en,
  input logic [1:0]        tog_en
);

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == REG_ADDR && !chip_rst_req) |=>
      (dptr_sel == $past(sfr_wdata[0]) && clk_lowpwr == $past(sfr_wdata[7])));

  // R3
  const_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rdata[2:1] == 2'b00);

  // R4
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr != REG_ADDR && !chip_rst_req) |=>
      ($stable(dptr_sel) && $stable(clk_lowpwr)));

  // R5
  srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == REG_ADDR && sfr_wdata[3] && !chip_rst_req) |=> chip_rst_req);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_req |=> !chip_rst_req);

  // R5
  clear_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_req |=> (!tog0_out && !tog1_out && !dptr_sel && !clk_lowpwr));

  // R6
  tog0_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_en[0] && t0_ovf && !chip_rst_req) |=> (tog0_out != $past(tog0_out)));

  // R6
  tog0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog_en[0] && !chip_rst_req) |=> $stable(tog0_out));

  // R7
  tog1_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_en[1] && t1_ovf && !chip_rst_req) |=> (tog1_out != $past(tog1_out)));

  // R7
  tog1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog_en[1] && !chip_rst_req) |=> $stable(tog1_out));

  // R8
  brk_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det && brk_en && !chip_rst_req) |=> (chip_rst_req && force_prog));

  // R8
  prog_with_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_prog |-> chip_rst_req);

  // R9
  brk_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det && !brk_en) |=> !force_prog);

endmodule

bind aux_ctrl_reg aux_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sfr_addr     (sfr_addr),
  .sfr_we       (sfr_we),
  .sfr_wdata    (sfr_wdata),
  .sfr_rdata    (sfr_rdata),
  .t0_ovf       (t0_ovf),
  .t1_ovf       (t1_ovf),
  .brk_det      (brk_det),
  .tog0_out     (tog0_out),
  .tog1_out     (tog1_out),
  .dptr_sel     (dptr_sel),
  .clk_lowpwr   (clk_lowpwr),
  .chip_rst_req (chip_rst_req),
  .force_prog   (force_prog),
  .brk_en       (brk_en_w),
  .tog_en       (tog_en_w)
);

// File: tb/aux_ctrl_reg_test.sv
module aux_ctrl_reg_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_REG = 8'hA2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       t0_ovf = 1'b0, t1_ovf = 1'b0, brk_det = 1'b0;
  logic       tog0_out, tog1_out, dptr_sel, clk_lowpwr, chip_rst_req, force_prog;

  int    vectors = 0;
  int    fails = 0;
  string cur_req = "R1";

  // reference model state
  logic [7:0] m_reg = 8'h00;
  bit m_t0 = 0, m_t1 = 0, m_rst = 0, m_prog = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_ctrl_reg uut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .t0_ovf(t0_ovf),
    .t1_ovf(t1_ovf), .brk_det(brk_det), .tog0_out(tog0_out),
    .tog1_out(tog1_out), .dptr_sel(dptr_sel), .clk_lowpwr(clk_lowpwr),
    .chip_rst_req(chip_rst_req), .force_prog(force_prog)
  );

  always @(posedge clk) begin : model
    bit pend, take, brk_go;
    if (!rst_n) begin
      m_reg = 0; m_t0 = 0; m_t1 = 0; m_rst = 0; m_prog = 0;
    end else begin
      pend   = m_rst;
      take   = sfr_we && (sfr_addr == A_REG) && !pend;
      brk_go = brk_det && m_reg[6] && !pend;
      if (pend) begin
        m_t0 = 0; m_t1 = 0;
      end else begin
        if (m_reg[4] && t0_ovf) m_t0 = !m_t0;
        if (m_reg[5] && t1_ovf) m_t1 = !m_t1;
      end
      m_rst  = (take && sfr_wdata[3]) || brk_go;
      m_prog = brk_go;
      if (pend)      m_reg = 8'h00;
      else if (take) m_reg = sfr_wdata & 8'b1111_1001;
    end
  end

  task automatic compare();
    logic [13:0] act, exp;
    logic [7:0]  exp_rd;
    exp_rd = (sfr_addr == A_REG) ? m_reg : 8'h00;
    act = {sfr_rdata, tog1_out, tog0_out, dptr_sel, clk_lowpwr, chip_rst_req, force_prog};
    exp = {exp_rd, m_t1, m_t0, m_reg[0], m_reg[7], m_rst, m_prog};
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (rdata,t1,t0,dptr,lp,rst,prog)",
               cur_req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_we = 1'b1; sfr_wdata = d;
    step();
    sfr_we = 1'b0; sfr_addr = A_REG;
  endtask

  task automatic rd(output logic [7:0] v);
    sfr_addr = A_REG;
    #1;
    v = sfr_rdata;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sfr_addr = A_REG;
    // R1: reset state
    cur_req = "R1";
    step(); step();

    // R2: field writes and readback
    cur_req = "R2";
    wr(A_REG, 8'hC1); step();
    wr(A_REG, 8'h80); step();
    wr(A_REG, 8'h01); step();

    // R3: constant bits and increment toggling of bit 0
    cur_req = "R3";
    wr(A_REG, 8'hF7); step();
    for (int k = 0; k < 4; k++) begin
      rd(v);
      wr(A_REG, v + 8'h01);
      step();
    end
    wr(A_REG, 8'h06); step();

    // R4: other addresses
    cur_req = "R4";
    wr(A_REG, 8'h81);
    sfr_addr = 8'hA3; step();
    sfr_addr = 8'h00; step();
    wr(8'hA1, 8'h00); step();
    wr(8'h22, 8'hFF); step();

    // R6: toggle output 0
    cur_req = "R6";
    wr(A_REG, 8'h10);
    for (int k = 0; k < 3; k++) begin
      t0_ovf = 1'b1; step(); t0_ovf = 1'b0; step(); step();
    end
    t0_ovf = 1'b1; step(); step(); t0_ovf = 1'b0; step();
    t1_ovf = 1'b1; step(); t1_ovf = 1'b0; step();
    wr(A_REG, 8'h00);
    t0_ovf = 1'b1; step(); step(); t0_ovf = 1'b0; step();

    // R7: toggle output 1, both together
    cur_req = "R7";
    wr(A_REG, 8'h20);
    t1_ovf = 1'b1; step(); t1_ovf = 1'b0; step();
    t0_ovf = 1'b1; step(); t0_ovf = 1'b0; step();
    wr(A_REG, 8'h30);
    t0_ovf = 1'b1; t1_ovf = 1'b1; step(); step(); step();
    t0_ovf = 1'b0; step(); t1_ovf = 1'b0; step();
    wr(A_REG, 8'h10);
    t1_ovf = 1'b1; step(); t1_ovf = 1'b0; step();

    // R9: break while disabled
    cur_req = "R9";
    wr(A_REG, 8'hB1);
    brk_det = 1'b1; step(); brk_det = 1'b0; step(); step();

    // R8: break while enabled
    cur_req = "R8";
    wr(A_REG, 8'h71);
    t0_ovf = 1'b1; step(); t0_ovf = 1'b0; step();
    brk_det = 1'b1; step(); brk_det = 1'b0; step(); step(); step();
    wr(A_REG, 8'h40);
    brk_det = 1'b1; step(); step(); brk_det = 1'b0; step(); step();

    // R5: software reset, write during pulse ignored
    cur_req = "R5";
    wr(A_REG, 8'h31);
    t0_ovf = 1'b1; t1_ovf = 1'b1; step(); t0_ovf = 1'b0; t1_ovf = 1'b0; step();
    wr(A_REG, 8'hB9);
    wr(A_REG, 8'h81);
    step(); step();
    wr(A_REG, 8'h08); step(); step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule